// File: doc/BRIEF.md
# General-Purpose Register Bank with Zero Entry

This block is the integer register storage of a single-cycle processor core. It has 32 words of 32 bits, two independent read ports and one write port. The instruction decoder gives the two source register numbers on the read selects. The operand words come back combinationally in the same cycle. The result of the instruction is written back through the write port at the next rising clock edge.

Entry 0 is a constant zero. Reads of entry 0 always return zero, and writes aimed at it are dropped. No value is forwarded from the write port to the read ports. A read of the register that is being written in the same cycle returns the value stored before the edge. The core must handle that case itself if it needs the new value. A synchronous active-high reset clears every entry. All pins are plain control and data signals with no handshake, because every access finishes in the cycle it is presented.

Top module: `gpr_bank`

## Requirements
- R1: When `wr_en` is high at a rising edge and `wr_sel` is not 0, entry `wr_sel` takes `wr_data`. From the next cycle, a read of that entry on either port returns that value.
- R2: At an edge where `wr_en` is low, no entry changes, whatever `wr_sel` and `wr_data` hold.
- R3: Each read port is combinational. A change of `rd_sel_a` or `rd_sel_b` shows on the matching data output within the same cycle, with no clock edge needed.
- R4: A read with select value 0 returns all zeros on either port at all times.
- R5: A write to select value 0 with `wr_en` high is discarded. Entry 0 still reads as zero afterwards.
- R6: A read of the entry being written in the same cycle returns the old value. The new value appears only after the edge.
- R7: When `rst` is high at a rising edge, every entry becomes zero, even if a write is requested at that same edge.
- R8: When both read selects carry the same value, both data outputs are identical.
- R9: The two read ports work independently. Different selects on the two ports return the contents of their own entries in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous active-high clear of all entries |
| rd_sel_a | input | 5 | Entry number for read port A |
| rd_data_a | output | 32 | Contents of entry `rd_sel_a` (combinational) |
| rd_sel_b | input | 5 | Entry number for read port B |
| rd_data_b | output | 32 | Contents of entry `rd_sel_b` (combinational) |
| wr_sel | input | 5 | Entry number for the write port |
| wr_data | input | 32 | Word to store |
| wr_en | input | 1 | Write enable, sampled at the rising edge |

## Verification
The bench aims at the zero entry first. It writes all ones to select 0 and reads the entry back. A design that gave entry 0 ordinary storage would return the written word instead of zero. The bench also reads an entry in the very cycle it is written. A design that added a bypass, or that sampled its reads after the edge, would show the new word one cycle early. The bench asserts reset together with a write request, which exposes a design where the write takes priority over the clear. It also steps a read select several times within one low clock phase, which exposes a registered read path. Random traffic puts equal and unequal selects on the two ports. This catches swapped or shared port multiplexers and writes that land on the wrong entry when the enable is low.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int unsigned DEF_DATA_W  = 32;
  localparam int unsigned DEF_ENTRIES = 32;
  localparam int unsigned NUM_RD      = 2;

  typedef enum logic [0:0] {
    PORT_A = 1'b0,
    PORT_B = 1'b1
  } rd_port_e;
endpackage

// File: rtl/gpr_wr_decode.sv
module gpr_wr_decode #(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned ADDR_W  = 5
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_sel,
  output logic [ENTRIES-1:0] strobe
);
  // One strobe per entry; entry 0 never gets one.
  always_comb begin
    strobe = '0;
    for (int i = 1; i < ENTRIES; i++) begin
      if (wr_en && (wr_sel == ADDR_W'(i))) strobe[i] = 1'b1;
    end
  end
endmodule

// File: rtl/gpr_storage.sv
module gpr_storage #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ENTRIES = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ENTRIES-1:0]        strobe,
  input  logic [DATA_W-1:0]         wr_data,
  output logic [ENTRIES*DATA_W-1:0] flat
);
  logic [DATA_W-1:0] mem [1:ENTRIES-1];

  // Reset wins over any pending write strobe.
  always_ff @(posedge clk) begin
    for (int i = 1; i < ENTRIES; i++) begin
      if (rst)            mem[i] <= '0;
      else if (strobe[i]) mem[i] <= wr_data;
    end
  end

  always_comb begin
    flat[DATA_W-1:0] = '0;
    for (int i = 1; i < ENTRIES; i++) flat[i*DATA_W +: DATA_W] = mem[i];
  end

  // R7: one edge with reset high leaves every entry cleared.
  a_r7_reset_clears: assert property (@(posedge clk) rst |=> (flat == '0))
    else $error("a_r7_reset_clears");
endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned ADDR_W  = 5
) (
  input  logic [ENTRIES*DATA_W-1:0] flat,
  input  logic [ADDR_W-1:0]         sel,
  output logic [DATA_W-1:0]         data
);
  always_comb begin
    data = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (sel == ADDR_W'(i)) data = flat[i*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/gpr_bank.sv
module gpr_bank
  import gpr_pkg::*;
#(
  parameter int unsigned DATA_W  = DEF_DATA_W,
  parameter int unsigned ENTRIES = DEF_ENTRIES,
  localparam int unsigned ADDR_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_sel_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [ADDR_W-1:0] rd_sel_b,
  output logic [DATA_W-1:0] rd_data_b,
  input  logic [ADDR_W-1:0] wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_en
);
  logic [ENTRIES-1:0]        strobe;
  logic [ENTRIES*DATA_W-1:0] flat;
  logic [ADDR_W-1:0]         sel_v  [NUM_RD];
  logic [DATA_W-1:0]         data_v [NUM_RD];

  gpr_wr_decode #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_dec (
    .wr_en (wr_en),
    .wr_sel(wr_sel),
    .strobe(strobe)
  );

  gpr_storage #(.DATA_W(DATA_W), .ENTRIES(ENTRIES)) u_store (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .wr_data(wr_data),
    .flat   (flat)
  );

  assign sel_v[PORT_A] = rd_sel_a;
  assign sel_v[PORT_B] = rd_sel_b;

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    gpr_read_port #(.DATA_W(DATA_W), .ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_port (
      .flat(flat),
      .sel (sel_v[p]),
      .data(data_v[p])
    );
  end

  assign rd_data_a = data_v[PORT_A];
  assign rd_data_b = data_v[PORT_B];

  // R4: select 0 reads zero on both ports.
  a_r4_zero_a: assert property (@(posedge clk) disable iff (rst)
    (rd_sel_a == '0) |-> (rd_data_a == '0)) else $error("a_r4_zero_a");
  a_r4_zero_b: assert property (@(posedge clk) disable iff (rst)
    (rd_sel_b == '0) |-> (rd_data_b == '0)) else $error("a_r4_zero_b");

  // R8: equal selects give equal data.
  a_r8_same_sel: assert property (@(posedge clk) disable iff (rst)
    (rd_sel_a == rd_sel_b) |-> (rd_data_a == rd_data_b)) else $error("a_r8_same_sel");

  // R1: a write is visible on the port one cycle later.
  a_r1_write_lands: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && ($past(wr_sel) != '0) && (rd_sel_a == $past(wr_sel)))
    |-> (rd_data_a == $past(wr_data))) else $error("a_r1_write_lands");

  // R2: an entry not written at the last edge keeps its value.
  a_r2_hold_b: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (rd_sel_b == $past(rd_sel_b)) &&
     !($past(wr_en) && ($past(wr_sel) == rd_sel_b)))
    |-> $stable(rd_data_b)) else $error("a_r2_hold_b");
endmodule

// File: tb/tb_gpr_bank.sv
`timescale 1ns/1ps
module tb_gpr_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rd_sel_a = '0, rd_sel_b = '0, wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        wr_en = 1'b0;
  logic [31:0] rd_data_a, rd_data_b;

  logic [31:0] model [32];
  int checks = 0;
  int errors = 0;

  gpr_bank dut (
    .clk(clk), .rst(rst),
    .rd_sel_a(rd_sel_a), .rd_data_a(rd_data_a),
    .rd_sel_b(rd_sel_b), .rd_data_b(rd_data_b),
    .wr_sel(wr_sel), .wr_data(wr_data), .wr_en(wr_en)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] expect_rd(input logic [4:0] s);
    return (s == 5'd0) ? 32'd0 : model[s];
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  // One clock: drive at falling edge, check reads before the rising edge, update model after.
  task automatic cyc(input string tag, input bit do_chk, input logic r, input logic we,
                     input logic [4:0] ws, input logic [31:0] wd,
                     input logic [4:0] ra, input logic [4:0] rb);
    @(negedge clk);
    rst = r; wr_en = we; wr_sel = ws; wr_data = wd; rd_sel_a = ra; rd_sel_b = rb;
    #2;
    if (do_chk) begin
      check(tag, rd_data_a, expect_rd(ra));
      check(tag, rd_data_b, expect_rd(rb));
    end
    @(posedge clk);
    #1;
    if (r) begin
      for (int i = 0; i < 32; i++) model[i] = '0;
    end else if (we && ws != 5'd0) begin
      model[ws] = wd;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed_ret;
    seed_ret = $urandom(32'd1759);
    for (int i = 0; i < 32; i++) model[i] = 'x;
    cyc("R7", 1'b0, 1'b1, 1'b0, 5'd0, 32'd0, 5'd0, 5'd0);
    cyc("R7", 1'b0, 1'b1, 1'b0, 5'd0, 32'd0, 5'd0, 5'd0);

    // R7: every entry reads zero after reset
    for (int i = 0; i < 32; i++)
      cyc("R7", 1'b1, 1'b0, 1'b0, 5'd0, 32'd0, 5'(i), 5'(31 - i));

    // R6: same-cycle read of the written entry gives the old value (0)
    cyc("R6", 1'b1, 1'b0, 1'b1, 5'd5, 32'hA5A5_5A5A, 5'd5, 5'd5);
    // R1: the new value is visible next cycle on both ports
    cyc("R1", 1'b1, 1'b0, 1'b0, 5'd0, 32'd0, 5'd5, 5'd5);
    check("R1", rd_data_a, 32'hA5A5_5A5A);

    // R5: a write to entry 0 is dropped
    cyc("R5", 1'b1, 1'b0, 1'b1, 5'd0, 32'hFFFF_FFFF, 5'd0, 5'd0);
    cyc("R5", 1'b1, 1'b0, 1'b0, 5'd0, 32'd0, 5'd0, 5'd0);
    check("R5", rd_data_b, 32'd0);

    // R2: enable low leaves the entry unchanged
    cyc("R2", 1'b1, 1'b0, 1'b0, 5'd5, 32'h1234_5678, 5'd5, 5'd0);
    cyc("R2", 1'b1, 1'b0, 1'b0, 5'd0, 32'd0, 5'd5, 5'd0);
    check("R2", rd_data_a, 32'hA5A5_5A5A);

    // R9: distinct entries on the two ports in one cycle
    cyc("R9", 1'b1, 1'b0, 1'b1, 5'd31, 32'hDEAD_BEEF, 5'd0, 5'd0);
    cyc("R9", 1'b1, 1'b0, 1'b0, 5'd0, 32'd0, 5'd31, 5'd5);

    // R3: selects stepped within one low phase, no clock edge in between
    @(negedge clk);
    wr_en = 1'b0;
    rd_sel_a = 5'd5;  #1; check("R3", rd_data_a, 32'hA5A5_5A5A);
    rd_sel_a = 5'd31; #1; check("R3", rd_data_a, 32'hDEAD_BEEF);
    rd_sel_b = 5'd31; #1; check("R3", rd_data_b, 32'hDEAD_BEEF);
    rd_sel_a = 5'd0;  #1; check("R3", rd_data_a, 32'd0);

    // Random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      logic        we;
      logic [4:0]  ws, ra, rb;
      logic [31:0] wd;
      string       tag;
      we = 1'($urandom_range(0, 3) != 0);
      ws = 5'($urandom_range(0, 31));
      wd = $urandom;
      ra = ($urandom_range(0, 3) == 0) ? ws : 5'($urandom_range(0, 31));
      rb = ($urandom_range(0, 4) == 0) ? ra : 5'($urandom_range(0, 31));
      if (we && ws == ra && ws != 5'd0) tag = "R6";
      else if (ra == rb)                tag = "R8";
      else if (ra == 5'd0 || rb == 5'd0) tag = "R4";
      else                              tag = "R9";
      cyc(tag, 1'b1, 1'b0, we, ws, wd, ra, rb);
    end

    // R7: reset with a simultaneous write still clears everything
    cyc("R7", 1'b1, 1'b1, 1'b1, 5'd9, 32'h0BAD_F00D, 5'd9, 5'd5);
    for (int i = 0; i < 32; i++) begin
      cyc("R7", 1'b1, 1'b0, 1'b0, 5'd0, 32'd0, 5'(i), 5'(i));
      check("R7", rd_data_a, 32'd0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule